// File: doc/BRIEF.md
# Cascaded Sample-Rate Pacer

This block turns a fixed 10 MHz reference clock (100 ns per tick) into a periodic sample strobe. The period is the product of two or three separately programmed 16-bit divisors. Each divisor has its own down-counter. A later counter moves only on the cycle in which every counter before it wraps. Two stages give a 32-bit divide range. The slowest two-stage setting, 65535 × 65535, gives a period of about 429.5 s. A third stage extends the range to 48 bits for very slow pacing.

Software loads the divisors through two plain write strobes that share one data word. The lower word holds the first and second divisors. The upper word holds the third divisor and the mode bit. When `enable` rises, the staged settings are checked. Every active divisor must be at least 2, and their product must be at least 100, which caps the rate at 100 kHz. A valid setting starts the pacer. An invalid one raises `error`, and the block stays idle. Writes made while the pacer runs are held back until the current period ends, so no period is ever shortened or mixed. The block has no data stream, so there is no valid/ready handshake anywhere. The strobe is a plain one-cycle pulse and is not back-pressured.

Top module: `sample_pacer`

## Requirements
- R1: After reset, `strobe`, `running` and `error` are all low.
- R2: In two-stage mode the strobe period is exactly N1·N2 clock cycles. N1 is `cfg_data[15:0]` and N2 is `cfg_data[31:16]`, both captured by `cfg_wr_lo`.
- R3: In three-stage mode the strobe period is exactly N1·N2·N3 cycles. N3 is `cfg_data[15:0]` captured by `cfg_wr_hi`. `cfg_data[16]` on the same write selects the mode: 1 means three stages, 0 means two stages.
- R4: `strobe` is high for exactly one cycle per period.
- R5: Let E be the rising clock edge that first samples `enable` high. With a valid setting, the first strobe appears just after the P-th rising edge after E, where P is the period.
- R6: If any active divisor is 0 or 1 when `enable` rises, `error` goes high after edge E, `running` stays low and no strobe is produced.
- R7: If every active divisor is at least 2 but their product is below 100, the block behaves as in R6.
- R8: In two-stage mode the third divisor is neither checked nor used.
- R9: A divisor write made while running leaves the current period unchanged. The new values set the period from the next strobe on.
- R10: If the staged values are invalid when a period completes, that period's strobe is still issued. On the same edge `running` drops and `error` rises.
- R11: When `enable` is low, `running` is low one edge later. A later valid start clears `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_lo | input | 1 | Capture N1 and N2 from `cfg_data` |
| cfg_wr_hi | input | 1 | Capture N3 and the mode bit from `cfg_data` |
| cfg_data | input | 32 | Write data for both configuration words |
| enable | input | 1 | Rising edge checks the settings and starts the pacer; low stops it |
| strobe | output | 1 | One-cycle sample pulse |
| running | output | 1 | Pacer is counting |
| error | output | 1 | Last check rejected the settings |

## Verification
The assertions assume that configuration writes never fall in the same cycle as the edge that samples the rise of `enable`. They also assume that a running pacer only ever holds divisors that passed the check, so every period is at least 100 cycles. The stimulus keeps to this. It issues writes only while the pacer is idle, or well inside a period that is already running. It raises `enable` one cycle after the last write. The random divisors are drawn small, with an occasional 0 or 1, so that valid periods end quickly and products below 100 occur often.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int unsigned DIV_W    = 16;
  localparam int unsigned N_STAGES = 3;
  localparam int unsigned PROD_W   = DIV_W * N_STAGES;
  typedef logic [DIV_W-1:0] div_t;
  typedef logic [N_STAGES-1:0][DIV_W-1:0] div_set_t;
endpackage

// File: rtl/pacer_check.sv
module pacer_check
  import pacer_pkg::*;
#(
  parameter int unsigned MIN_DIV  = 2,
  parameter int unsigned MIN_PROD = 100
) (
  input  div_set_t divs,
  input  logic     three,
  output logic     ok
);
  localparam int unsigned P2_W = 2 * DIV_W;

  logic [N_STAGES-1:0] div_ok;
  logic [P2_W-1:0]     prod2;
  logic [PROD_W-1:0]   prod3;

  genvar g;
  generate
    for (g = 0; g < N_STAGES; g++) begin : g_rng
      assign div_ok[g] = (divs[g] >= DIV_W'(MIN_DIV));
    end
  endgenerate

  always_comb begin
    prod2 = P2_W'(divs[0]) * P2_W'(divs[1]);
    prod3 = PROD_W'(prod2) * PROD_W'(divs[2]);
    if (three)
      ok = &div_ok && (prod3 >= PROD_W'(MIN_PROD));
    else
      ok = div_ok[0] && div_ok[1] && (prod2 >= P2_W'(MIN_PROD));
  end
endmodule

// File: rtl/pacer_stage.sv
module pacer_stage
  import pacer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  div_t load_val,
  input  logic step,
  output logic tc
);
  div_t cnt;
  div_t div_q;

  assign tc = (cnt == DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else if (load) begin
      cnt   <= load_val;
      div_q <= load_val;
    end else if (step) begin
      cnt <= tc ? div_q : cnt - DIV_W'(1);
    end
  end

  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt));
  p_stage_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !tc) |=> (cnt == $past(cnt) - DIV_W'(1)));
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer
  import pacer_pkg::*;
#(
  parameter int unsigned MIN_DIV  = 2,
  parameter int unsigned MIN_PROD = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_lo,
  input  logic        cfg_wr_hi,
  input  logic [31:0] cfg_data,
  input  logic        enable,
  output logic        strobe,
  output logic        running,
  output logic        error
);
  div_set_t            pend;
  logic                pend_three;
  logic                act_three;
  logic                en_q;
  logic                cfg_ok;
  logic [N_STAGES-1:0] step;
  logic [N_STAGES-1:0] tc;
  logic                full_tc;
  logic                start;
  logic                load_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      pend_three <= 1'b0;
    end else begin
      if (cfg_wr_lo) begin
        pend[0] <= cfg_data[15:0];
        pend[1] <= cfg_data[31:16];
      end
      if (cfg_wr_hi) begin
        pend[2]    <= cfg_data[15:0];
        pend_three <= cfg_data[16];
      end
    end
  end

  pacer_check #(.MIN_DIV(MIN_DIV), .MIN_PROD(MIN_PROD)) u_check (
    .divs  (pend),
    .three (pend_three),
    .ok    (cfg_ok)
  );

  assign start    = enable && !en_q;
  assign full_tc  = act_three ? (step[2] && tc[2]) : (step[1] && tc[1]);
  assign load_all = enable && cfg_ok && (start || full_tc);

  genvar g;
  generate
    for (g = 0; g < N_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign step[g] = running;
      end else begin : g_next
        assign step[g] = step[g-1] && tc[g-1];
      end
      pacer_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_all),
        .load_val (pend[g]),
        .step     (step[g]),
        .tc       (tc[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      strobe    <= 1'b0;
      running   <= 1'b0;
      error     <= 1'b0;
      act_three <= 1'b0;
    end else begin
      en_q   <= enable;
      strobe <= full_tc;
      if (load_all) act_three <= pend_three;
      if (!enable) begin
        running <= 1'b0;
      end else if (start) begin
        running <= cfg_ok;
        error   <= !cfg_ok;
      end else if (full_tc && !cfg_ok) begin
        running <= 1'b0;
        error   <= 1'b1;
      end
    end
  end

  p_error_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !running);
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  p_strobe_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(running));
  p_start_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> !error);
  p_stop_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !running);
endmodule

// File: tb/sample_pacer_bench.sv
module sample_pacer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_lo = 1'b0;
  logic        cfg_wr_hi = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        enable = 1'b0;
  logic        strobe, running, error;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  sample_pacer u_sample_pacer (
    .clk(clk), .rst_n(rst_n), .cfg_wr_lo(cfg_wr_lo), .cfg_wr_hi(cfg_wr_hi),
    .cfg_data(cfg_data), .enable(enable),
    .strobe(strobe), .running(running), .error(error)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      report();
    end
  end

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ok(int n1, int n2, int n3, bit three);
    if (n1 < 2 || n2 < 2) return 0;
    if (three && n3 < 2) return 0;
    return (three ? n1 * n2 * n3 : n1 * n2) >= 100;
  endfunction

  function automatic int exp_period(int n1, int n2, int n3, bit three);
    return three ? n1 * n2 * n3 : n1 * n2;
  endfunction

  task automatic write_cfg(int n1, int n2, int n3, bit three);
    @(negedge clk);
    cfg_wr_lo = 1'b1; cfg_data = {n2[15:0], n1[15:0]};
    @(negedge clk);
    cfg_wr_lo = 1'b0; cfg_wr_hi = 1'b1; cfg_data = {15'd0, three, n3[15:0]};
    @(negedge clk);
    cfg_wr_hi = 1'b0; cfg_data = '0;
  endtask

  task automatic wait_strobe(int maxc, output int c);
    c = 0;
    do begin
      @(posedge clk); @(negedge clk);
      c++;
    end while (!strobe && c < maxc);
  endtask

  task automatic stop_run();
    @(negedge clk); enable = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!running, "R11", "running after enable low", running, 0);
    @(negedge clk);
  endtask

  task automatic run_case(int n1, int n2, int n3, bit three);
    int c;
    int p = exp_period(n1, n2, n3, three);
    string rq = three ? "R3" : "R2";
    write_cfg(n1, n2, n3, three);
    enable = 1'b1;
    if (exp_ok(n1, n2, n3, three)) begin
      wait_strobe(p + 5, c);
      check(c == p + 1, "R5", "first strobe latency", c, p + 1);
      wait_strobe(p + 5, c);
      check(c == p, rq, "strobe period", c, p);
      @(posedge clk); @(negedge clk);
      check(!strobe, "R4", "strobe width", strobe, 0);
    end else begin
      @(posedge clk); @(negedge clk);
      check(error && !running, (n1 < 2 || n2 < 2 || (three && n3 < 2)) ? "R6" : "R7",
            "error/running after bad start", {error, running}, 2);
      wait_strobe(150, c);
      check(!strobe, "R6", "no strobe while rejected", strobe, 0);
    end
    stop_run();
  endtask

  initial begin
    int c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!strobe && !running && !error, "R1", "outputs after reset",
          {strobe, running, error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!strobe && !running && !error, "R1", "outputs after release",
          {strobe, running, error}, 0);

    run_case(10, 10, 0, 1'b0);   // R2 exact minimum product, R8 N3=0 ignored
    check(n_fail == 0, "R8", "two-stage ignores N3=0", n_fail, 0);
    run_case(2, 2, 25, 1'b1);    // R3 minimum three-stage
    run_case(1, 200, 2, 1'b0);   // R6 divisor of one
    run_case(5, 5, 0, 1'b1);     // R6 third divisor zero in three-stage
    run_case(9, 11, 3, 1'b0);    // R7 product 99
    run_case(3, 3, 11, 1'b1);    // R7 product 99 in three-stage

    for (int i = 0; i < 28; i++) begin
      int n1 = 2 + int'($urandom % 14);
      int n2 = 2 + int'($urandom % 14);
      int n3 = 2 + int'($urandom % 3);
      bit th = 1'($urandom % 2);
      if ($urandom % 8 == 0) n1 = int'($urandom % 2);
      run_case(n1, n2, n3, th);
    end

    // R9: mid-run write takes effect only after the next strobe
    write_cfg(12, 10, 0, 1'b0);
    enable = 1'b1;
    wait_strobe(200, c);
    repeat (20) @(negedge clk);
    cfg_wr_lo = 1'b1; cfg_data = {16'd15, 16'd10};
    @(negedge clk); cfg_wr_lo = 1'b0; cfg_data = '0;
    wait_strobe(200, c);
    check(c == 120 - 21, "R9", "period holding write", c + 21, 120);
    wait_strobe(200, c);
    check(c == 150, "R9", "period after write", c, 150);

    // R10: invalid staged values at terminal count
    repeat (10) @(negedge clk);
    cfg_wr_lo = 1'b1; cfg_data = {16'd15, 16'd1};
    @(negedge clk); cfg_wr_lo = 1'b0; cfg_data = '0;
    wait_strobe(200, c);
    check(strobe && c == 150 - 11, "R10", "final strobe cycle", c + 11, 150);
    check(error && !running, "R10", "error/running at stop", {error, running}, 2);
    stop_run();

    // R11: valid restart clears error
    write_cfg(20, 5, 0, 1'b0);
    enable = 1'b1;
    @(posedge clk); @(negedge clk);
    check(!error && running, "R11", "error/running after restart", {error, running}, 1);
    stop_run();
    report();
  end
endmodule